// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This block sits on the host side of a flash memory. It waits for an internal program or erase operation to finish once the command sequence has been written. A start pulse supplies the polling method, the operation type, the expected data word and the word address. The engine then reads that address through a simple request/response read port until the status bits show that the operation has finished.

Two methods are available. The data-complement method watches bit 7. During a program, bit 7 reads back as the inverse of the written bit. During an erase, bit 7 reads as 0. The toggle method watches bit 6, which flips on every read while the operation is still running. A read can land exactly on the moment the operation finishes. Its status bits can then report completion while the rest of the word is not yet valid. When that happens, the engine waits a settling gap and then makes two confirmation reads before it accepts completion. The engine ends with a one-cycle done pulse, or with a one-cycle timeout pulse when its read budget runs out. In both cases the last word read is left on the result output.

Top module: `fpoll_engine`

## Requirements
- R1: With the data-complement method on a program, a read finishes the operation when its bit 7 equals bit 7 of the expected word and the whole word equals the expected word.
- R2: With the data-complement method on an erase, a read finishes the operation when its bit 7 is 1 and the whole word is all ones.
- R3: With the toggle method, the status shows completion only when bit 6 of a read equals bit 6 of the previous read in the same run. The first read of a run can never finish it. The word must still equal the target: the expected word for a program, all ones for an erase.
- R4: If a polling read shows completion in its status bit but the word does not match the target, the next request is delayed by SETTLE_CYC+1 extra cycles. Two confirmation reads follow. Completion is accepted only if both reads show completion and match. If either one fails, plain polling resumes.
- R5: If MAX_READS reads have been made without completion, timeout_o pulses for exactly one cycle and the engine goes idle. This holds even when the last read starts a confirmation. done_o and timeout_o are never high together.
- R6: done_o pulses for exactly one cycle, in the cycle after the clock edge that accepts the deciding read data. result_o holds the most recently accepted read word.
- R7: Only one read is outstanding at a time. rd_req_o is high for one cycle, and no new request is made until rd_valid_i returns. rd_addr_o is the address latched at start. The next request follows one cycle after the read data arrives.
- R8: A start_i pulse while busy is ignored; the method, expected word and address captured at start stay in force. rd_valid_i with no read outstanding is ignored and leaves result_o unchanged.
- R9: Under reset the engine is idle. busy_o, rd_req_o, done_o, timeout_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a polling run (taken only when idle) |
| use_toggle_i | input | 1 | 1 = toggle method on bit 6, 0 = data-complement method on bit 7 |
| erase_i | input | 1 | 1 = an erase is in progress, 0 = a program |
| expect_i | input | DW | Word that was programmed |
| addr_i | input | AW | Address to poll |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | One-cycle timeout pulse |
| result_o | output | DW | Last accepted read word |

## Verification
Every result is due at a fixed cycle. The first request appears in the cycle after start. Each later request comes one cycle after the read data arrives, or SETTLE_CYC+2 cycles after it when the read opens a confirmation. The done or timeout pulse appears one cycle after the deciding data. The bench drives inputs and samples outputs on the falling edge. At each edge it records the gap between the delivery of each read and the next request. A behavioural model walks the same queue of read words and gives the expected read count, outcome, final word and gap list. All of these are compared once the run has ended.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_SETTLE
  } fsm_t;

  typedef enum logic [1:0] {
    PH_POLL,
    PH_CONF1,
    PH_CONF2
  } phase_t;

  typedef struct packed {
    logic   win;
    logic   to_settle;
    phase_t nxt;
  } step_t;

  // Does the status bit alone say the internal operation has ended?
  function automatic logic status_says_done(
    input logic tog_mode,
    input logic is_erase,
    input logic have_prev,
    input logic prev_tog,
    input logic cur_tog,
    input logic cur_stat,
    input logic exp_stat
  );
    if (tog_mode) return have_prev && (cur_tog == prev_tog);
    if (is_erase) return cur_stat;
    return cur_stat == exp_stat;
  endfunction

  // Phase stepping of the polling / double confirmation sequence.
  function automatic step_t judge_step(
    input phase_t ph,
    input logic   st_ok,
    input logic   wd_ok
  );
    step_t s;
    s.win       = 1'b0;
    s.to_settle = 1'b0;
    s.nxt       = PH_POLL;
    unique case (ph)
      PH_POLL: begin
        s.win       = st_ok && wd_ok;
        s.to_settle = st_ok && !wd_ok;
        s.nxt       = s.to_settle ? PH_CONF1 : PH_POLL;
      end
      PH_CONF1: s.nxt = (st_ok && wd_ok) ? PH_CONF2 : PH_POLL;
      PH_CONF2: s.win = st_ok && wd_ok;
      default:  s.nxt = PH_POLL;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fpoll_judge.sv
module fpoll_judge #(
  parameter int DW       = 16,
  parameter int STAT_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          use_toggle,
  input  logic          erase,
  input  logic          have_prev,
  input  logic          prev_tog,
  input  logic [DW-1:0] rd_word,
  input  logic [DW-1:0] exp_word,
  output logic          status_ok,
  output logic          word_ok
);
  logic [DW-1:0] target;

  always_comb begin
    target    = erase ? {DW{1'b1}} : exp_word;
    status_ok = fpoll_pkg::status_says_done(use_toggle, erase, have_prev, prev_tog,
                                            rd_word[TOG_BIT], rd_word[STAT_BIT],
                                            exp_word[STAT_BIT]);
    word_ok   = (rd_word == target);
  end
endmodule

// File: rtl/fpoll_settle.sv
module fpoll_settle #(
  parameter int CYC = 50,
  parameter int CW  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/fpoll_budget.sv
module fpoll_budget #(
  parameter int LIMIT = 64,
  parameter int CW    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/fpoll_engine.sv
module fpoll_engine #(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int MAX_READS  = 64,
  parameter int SETTLE_CYC = 50,
  parameter int STAT_BIT   = 7,
  parameter int TOG_BIT    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          use_toggle_i,
  input  logic          erase_i,
  input  logic [DW-1:0] expect_i,
  input  logic [AW-1:0] addr_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic [DW-1:0] result_o
);
  import fpoll_pkg::*;

  localparam int SCW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam int BCW = $clog2(MAX_READS + 1);

  fsm_t          st;
  phase_t        ph;
  logic          tog_q, ers_q, have_prev, prev_tog;
  logic [DW-1:0] exp_q;
  logic [AW-1:0] addr_q;

  // named internal events
  logic  start_take, rd_take, status_ok, word_ok, at_last, settle_done;
  logic  ev_win, ev_exhaust, ev_confirm;
  step_t step;

  assign start_take = (st == ST_IDLE) && start_i;
  assign rd_take    = (st == ST_WAIT) && rd_valid_i;

  fpoll_judge #(.DW(DW), .STAT_BIT(STAT_BIT), .TOG_BIT(TOG_BIT)) u_judge (
    .use_toggle (tog_q),
    .erase      (ers_q),
    .have_prev  (have_prev),
    .prev_tog   (prev_tog),
    .rd_word    (rd_data_i),
    .exp_word   (exp_q),
    .status_ok  (status_ok),
    .word_ok    (word_ok)
  );

  assign step       = judge_step(ph, status_ok, word_ok);
  assign ev_win     = rd_take && step.win;
  assign ev_exhaust = rd_take && !step.win && at_last;
  assign ev_confirm = rd_take && step.to_settle && !at_last;

  fpoll_budget #(.LIMIT(MAX_READS), .CW(BCW)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_take),
    .inc     (rd_take),
    .at_last (at_last)
  );

  fpoll_settle #(.CYC(SETTLE_CYC), .CW(SCW)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_confirm),
    .expired (settle_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= PH_POLL;
      tog_q     <= 1'b0;
      ers_q     <= 1'b0;
      exp_q     <= '0;
      addr_q    <= '0;
      have_prev <= 1'b0;
      prev_tog  <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      result_o  <= '0;
    end else begin
      done_o    <= ev_win;
      timeout_o <= ev_exhaust;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            tog_q     <= use_toggle_i;
            ers_q     <= erase_i;
            exp_q     <= expect_i;
            addr_q    <= addr_i;
            have_prev <= 1'b0;
            ph        <= PH_POLL;
            st        <= ST_ISSUE;
          end
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (rd_valid_i) begin
            result_o  <= rd_data_i;
            have_prev <= 1'b1;
            prev_tog  <= rd_data_i[TOG_BIT];
            ph        <= step.nxt;
            if (ev_win || ev_exhaust) st <= ST_IDLE;
            else if (ev_confirm)      st <= ST_SETTLE;
            else                      st <= ST_ISSUE;
          end
        end
        ST_SETTLE: if (settle_done) st <= ST_ISSUE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (st == ST_ISSUE);
  assign rd_addr_o = addr_q;
  assign busy_o    = (st != ST_IDLE);
endmodule

// File: rtl/fpoll_checker.sv
module fpoll_checker #(
  parameter int AW        = 20,
  parameter int MAX_READS = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          rd_req_o,
  input logic          rd_valid_i,
  input logic [AW-1:0] rd_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          timeout_o,
  input logic          rd_take
);
  int unsigned takes;

  always_ff @(posedge clk) begin
    if (!rst_n)                  takes <= 0;
    else if (start_i && !busy_o) takes <= 0;
    else if (rd_take)            takes <= takes + 1;
  end

  a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  a_r7_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rd_take) && $past(rd_valid_i)));
  a_r5_timeout_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));
  a_r5_budget: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (takes == MAX_READS));
  a_r5_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (takes <= MAX_READS));
  a_r8_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o) |-> !busy_o);
endmodule

bind fpoll_engine fpoll_checker #(.AW(AW), .MAX_READS(MAX_READS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .rd_req_o   (rd_req_o),
  .rd_valid_i (rd_valid_i),
  .rd_addr_o  (rd_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .timeout_o  (timeout_o),
  .rd_take    (rd_take)
);

// File: tb/sim_fpoll_engine.sv
module sim_fpoll_engine;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int MAXR = 8;
  localparam int SET = 3;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, use_toggle_i = 1'b0, erase_i = 1'b0;
  logic [DW-1:0] expect_i = '0, rd_data_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic rd_valid_i = 1'b0;
  logic rd_req_o, busy_o, done_o, timeout_o;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] result_o;

  fpoll_engine #(.AW(AW), .DW(DW), .MAX_READS(MAXR), .SETTLE_CYC(SET)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .use_toggle_i(use_toggle_i),
    .erase_i(erase_i), .expect_i(expect_i), .addr_i(addr_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o), .result_o(result_o)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] wq[$];
  logic [15:0] rsp_q[$];
  int gap_meas[$];
  int exp_gap[$];
  int nreads = 0, gap_cnt = 0, done_seen = 0, to_seen = 0;
  bit pend = 0, gap_arm = 0, stray_req = 0, prev_done = 0, prev_to = 0;
  logic [15:0] end_result = '0;
  logic [AW-1:0] cur_addr = '0;
  // model outputs
  int m_outcome, m_reads;
  logic [15:0] m_last;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Read responder and pulse monitor, all on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (done_o) begin done_seen++; end_result = result_o; end
      if (timeout_o) begin to_seen++; end_result = result_o; end
      if (done_o && prev_done) chk(0, "R6", "done pulse width", 2, 1);
      if (timeout_o && prev_to) chk(0, "R5", "timeout pulse width", 2, 1);
      prev_done = done_o;
      prev_to = timeout_o;
      rd_valid_i = 1'b0;
      if (gap_arm) gap_cnt++;
      if (pend) begin
        rd_valid_i = 1'b1;
        rd_data_i = (rsp_q.size() > 0) ? rsp_q.pop_front() : 16'h0080;
        pend = 0;
        nreads++;
        gap_arm = 1;
        gap_cnt = 0;
      end else if (stray_req) begin
        rd_valid_i = 1'b1;
        rd_data_i = 16'hBEEF;
        stray_req = 0;
      end else if (rd_req_o) begin
        pend = 1;
        if (gap_arm) begin gap_meas.push_back(gap_cnt); gap_arm = 0; end
        chk(rd_addr_o == cur_addr, "R7", "read address", rd_addr_o, cur_addr);
      end
    end
  end

  // Behavioural model: walks the response words in order.
  task automatic predict(input bit tog, input bit ers, input logic [15:0] ex);
    int idx = 0, ph = 0;
    bit have = 0, pb = 0, stat, ok;
    logic [15:0] w, tgt;
    exp_gap.delete();
    tgt = ers ? 16'hFFFF : ex;
    m_outcome = 0;
    while (m_outcome == 0) begin
      w = (idx < wq.size()) ? wq[idx] : 16'h0080;
      idx++;
      if (tog) stat = have && (w[6] == pb);
      else if (ers) stat = w[7];
      else stat = (w[7] == ex[7]);
      ok = stat && (w == tgt);
      have = 1;
      pb = w[6];
      m_last = w;
      if (ph == 0 && ok) m_outcome = 1;
      else if (ph == 2 && ok) m_outcome = 1;
      else if (idx == MAXR) m_outcome = 2;
      else begin
        if (ph == 0 && stat) begin ph = 1; exp_gap.push_back(SET + 2); end
        else begin ph = (ph == 1 && ok) ? 2 : 0; exp_gap.push_back(1); end
      end
    end
    m_reads = idx;
  endtask

  task automatic run_case(input string tag, input bit tog, input bit ers,
                          input logic [15:0] ex, input bit mid_start);
    predict(tog, ers, ex);
    rsp_q = wq;
    gap_meas.delete();
    gap_arm = 0; nreads = 0; done_seen = 0; to_seen = 0;
    cur_addr = AW'(20'h45A00 + wq.size());
    @(negedge clk);
    start_i = 1; use_toggle_i = tog; erase_i = ers; expect_i = ex; addr_i = cur_addr;
    @(negedge clk);
    start_i = 0; addr_i = ~cur_addr; expect_i = ~ex;
    if (mid_start) begin
      repeat (3) @(negedge clk);
      start_i = 1; use_toggle_i = !tog; erase_i = !ers;
      @(negedge clk);
      start_i = 0;
    end
    for (int i = 0; i < 400 && done_seen == 0 && to_seen == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_seen == ((m_outcome == 1) ? 1 : 0), tag, "done pulses", done_seen, m_outcome == 1);
    chk(to_seen == ((m_outcome == 2) ? 1 : 0), tag, "timeout pulses", to_seen, m_outcome == 2);
    chk(nreads == m_reads, tag, "read count", nreads, m_reads);
    chk(end_result == m_last, tag, "result word", end_result, m_last);
    chk(result_o == m_last, "R6", "result held", result_o, m_last);
    chk(!busy_o, tag, "idle after run", busy_o, 0);
    chk(gap_meas.size() == exp_gap.size(), "R7", "gap count", gap_meas.size(), exp_gap.size());
    for (int i = 0; i < gap_meas.size() && i < exp_gap.size(); i++)
      chk(gap_meas[i] == exp_gap[i], (exp_gap[i] == 1) ? "R7" : "R4", "request gap",
          gap_meas[i], exp_gap[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy_o, "R9", "busy in reset", busy_o, 0);
    chk(!rd_req_o, "R9", "req in reset", rd_req_o, 0);
    chk(!done_o && !timeout_o, "R9", "pulses in reset", {done_o, timeout_o}, 0);
    chk(result_o == 16'h0, "R9", "result in reset", result_o, 0);
    rst_n = 1;

    // R1 program, data-complement method
    wq = {16'h3CDA, 16'h3C9A, 16'h3CDA, 16'h3C5A};
    run_case("R1", 0, 0, 16'h3C5A, 0);
    // R2 erase, data-complement method
    wq = {16'h0040, 16'h0000, 16'h7F7F, 16'hFFFF};
    run_case("R2", 0, 1, 16'h1234, 0);
    // R3 toggle method on a program
    wq = {16'h0040, 16'h0000, 16'h0040, 16'hA5C3};
    run_case("R3", 1, 0, 16'hA5C3, 0);
    // R3 first read never finishes in toggle mode
    wq = {16'hA5C3, 16'hA5C3};
    run_case("R3", 1, 0, 16'hA5C3, 0);
    // R3 toggle method on an erase
    wq = {16'h0040, 16'h0000, 16'hFFFF, 16'hFFFF};
    run_case("R3", 1, 1, 16'h0000, 0);
    // R4 conflict confirmed by two good reads
    wq = {16'h3CDA, 16'h3C50, 16'h3C5A, 16'h3C5A};
    run_case("R4", 0, 0, 16'h3C5A, 0);
    // R4 first confirmation fails, polling resumes
    wq = {16'h3C50, 16'h3CDA, 16'h3C5A};
    run_case("R4", 0, 0, 16'h3C5A, 0);
    // R4 second confirmation fails, polling resumes
    wq = {16'h3C50, 16'h3C5A, 16'h3C51, 16'h3C5A};
    run_case("R4", 0, 0, 16'h3C5A, 0);
    // R5 timeout while busy throughout
    wq.delete();
    for (int i = 0; i < MAXR; i++) wq.push_back(16'h3CDA ^ 16'(i));
    run_case("R5", 0, 0, 16'h3C5A, 0);
    // R5 timeout when the final read opens a confirmation
    wq.delete();
    for (int i = 0; i < MAXR - 1; i++) wq.push_back(16'h3CDA);
    wq.push_back(16'h3C50);
    run_case("R5", 0, 0, 16'h3C5A, 0);
    // R8 start while busy is ignored
    wq = {16'h3CDA, 16'h3C9A, 16'h3CDA, 16'h3C5A};
    run_case("R8", 0, 0, 16'h3C5A, 1);
    // R8 stray read data while idle is ignored
    stray_req = 1;
    repeat (4) @(negedge clk);
    chk(result_o == 16'h3C5A, "R8", "result after stray data", result_o, 16'h3C5A);
    chk(!busy_o && done_seen == 1 && to_seen == 0, "R8", "no reaction to stray data",
        {busy_o, done_seen[1:0], to_seen[1:0]}, 3'b010);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule